// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Block

This block gathers up to 32 interrupt sources into one interrupt line. Each source has one bit index, and that index means the same source in every register. Hardware events arrive as single-cycle pulses on a source vector and latch into a sticky cause register. Software can also raise a cause bit through a write-only set port. Each bit is cleared by one of two rules, chosen per bit at run time. In write-one-to-clear mode a 1 written to the bit clears it. In clear-on-read mode a read that returns the bit clears it.

A mask register hides sources from the interrupt output. Software can write the whole mask at once, or use two alias ports that set or clear only the bits written as 1. A masked-cause view returns the cause bits that the mask lets through. Accesses to this view clear bits under the same per-bit rule as the raw cause, but only the bits that the view exposes. The interrupt output is high whenever any unmasked cause bit is set.

Registers are reached through a word-indexed port: a write strobe and a read strobe share one word index. Read data is registered and appears on the cycle after the read strobe.

Top module: `irq_cause_mask_unit`

## Requirements
- R1: While reset is high and after it is released, the cause register and the clear-mode control are all zeros, every mask bit is 1, and the interrupt output is low.
- R2: A 1 on any event input bit sets the matching cause bit at the next clock edge, and the bit stays set until it is cleared. A cause bit never becomes set without an event or a cause-set write.
- R3: When the clear-mode bit of a source is 0 (write-one-to-clear), writing 1 to that bit of the cause register (word 1, byte offset 0x04) clears it. Writing 0 leaves it unchanged, and reading the cause does not change it.
- R4: When the clear-mode bit of a source is 1 (clear-on-read), a read of the cause register returns the bit and clears it. Writes to that bit of the cause register have no effect.
- R5: The masked-cause register (word 2, offset 0x08) reads as cause AND NOT mask, where a mask bit of 1 hides its source. A read of this register clears only returned bits in clear-on-read mode. A write to it clears only bits that are in write-one-to-clear mode and not masked.
- R6: Writing 1s to the cause-set port (word 3, offset 0x0C) sets those cause bits. This port reads as zero.
- R7: The mask value register (word 4, offset 0x10) is read and written directly. Writing 1s to the mask-set port (word 5, offset 0x14) sets those mask bits, and writing 1s to the mask-clear port (word 6, offset 0x18) clears them. Zero bits leave the mask unchanged. Both alias ports read as zero.
- R8: When an event and a clear (write-one-to-clear write or clear-on-read read) hit the same bit in the same cycle, the event wins and the bit stays set.
- R9: The interrupt output equals the OR of all masked-cause bits. It follows the registered cause and mask with no extra delay.
- R10: Read data is registered and holds the value of the word read, as it stood before the clock edge of the read, starting on the cycle after the read strobe. A read or write of the unused word 7 (offset 0x1C) returns zero and changes no state.
- R11: The clear-mode control (word 0, offset 0x00) is read and written directly. A bit value of 0 selects write-one-to-clear and a bit value of 1 selects clear-on-read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Word index of the register accessed |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| evt_pulse | input | 32 | Hardware event pulses, one bit per source |
| irq_out | output | 1 | Aggregated interrupt request |

## Verification
On every cycle, the assertions check the following: the reset state, that events stick and that no cause bit appears without a cause, that a clear-on-read read leaves no unprotected mode-1 bit behind, that a plain read keeps mode-0 bits, that write-only ports return zero, and that the interrupt output matches the masked cause. Some behaviour needs the bench's scenarios. These are the clear-mode sweep over all 32 bits, the precedence of an event over a same-cycle clear, the restriction of masked-view clears to visible bits, the accumulating mask-set and mask-clear sequences, and the unused word.

// File: rtl/irq_cm_pkg.sv
package irq_cm_pkg;

    // Word slots of the register port; the index is the word address
    typedef enum logic [2:0] {
        SLOT_MODE   = 3'd0,
        SLOT_CAUSE  = 3'd1,
        SLOT_MCAUSE = 3'd2,
        SLOT_RAISE  = 3'd3,
        SLOT_MVAL   = 3'd4,
        SLOT_MSET   = 3'd5,
        SLOT_MCLR   = 3'd6,
        SLOT_NONE   = 3'd7
    } slot_e;

    // Decoded per-register strobes for one access
    typedef struct packed {
        logic mode_we;
        logic cause_we;
        logic mcause_we;
        logic raise_we;
        logic mval_we;
        logic mset_we;
        logic mclr_we;
        logic cause_re;
        logic mcause_re;
    } strobe_t;

    localparam int unsigned SLOT_COUNT = 7;

    // Slots that read back as zero regardless of state
    function automatic logic slot_reads_zero(slot_e s);
        return (s == SLOT_RAISE) || (s == SLOT_MSET) ||
               (s == SLOT_MCLR)  || (s == SLOT_NONE);
    endfunction

endpackage

// File: rtl/irq_cm_decode.sv
module irq_cm_decode
    import irq_cm_pkg::*;
#(
    parameter int unsigned AW = 3
) (
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic          rd,
    output slot_e         slot,
    output strobe_t       strb
);
    localparam logic [AW-1:0] LAST_WORD = AW'(SLOT_COUNT - 1);

    always_comb begin
        if (addr <= LAST_WORD) begin
            slot = slot_e'(addr[2:0]);
        end else begin
            slot = SLOT_NONE;
        end
    end

    always_comb begin
        strb           = '0;
        strb.mode_we   = wr && (slot == SLOT_MODE);
        strb.cause_we  = wr && (slot == SLOT_CAUSE);
        strb.mcause_we = wr && (slot == SLOT_MCAUSE);
        strb.raise_we  = wr && (slot == SLOT_RAISE);
        strb.mval_we   = wr && (slot == SLOT_MVAL);
        strb.mset_we   = wr && (slot == SLOT_MSET);
        strb.mclr_we   = wr && (slot == SLOT_MCLR);
        strb.cause_re  = rd && (slot == SLOT_CAUSE);
        strb.mcause_re = rd && (slot == SLOT_MCAUSE);
    end

endmodule

// File: rtl/irq_cm_cause.sv
module irq_cm_cause #(
    parameter int unsigned NSRC = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] evt,
    input  logic [NSRC-1:0] wdata,
    input  logic [NSRC-1:0] mask,
    input  logic            mode_we,
    input  logic            cause_we,
    input  logic            mcause_we,
    input  logic            raise_we,
    input  logic            cause_re,
    input  logic            mcause_re,
    output logic [NSRC-1:0] mode_q,
    output logic [NSRC-1:0] cause_q
);
    logic [NSRC-1:0] visible;
    logic [NSRC-1:0] w1c_hit;
    logic [NSRC-1:0] cor_hit;
    logic [NSRC-1:0] raise_bits;

    assign visible = cause_q & ~mask;

    // Write-one-to-clear candidates: mode 0 bits written as 1
    always_comb begin
        w1c_hit = '0;
        if (cause_we)  w1c_hit = w1c_hit | wdata;
        if (mcause_we) w1c_hit = w1c_hit | (wdata & ~mask);
        w1c_hit = w1c_hit & ~mode_q;
    end

    // Clear-on-read candidates: mode 1 bits returned by this read
    always_comb begin
        cor_hit = '0;
        if (cause_re)  cor_hit = cor_hit | cause_q;
        if (mcause_re) cor_hit = cor_hit | visible;
        cor_hit = cor_hit & mode_q;
    end

    assign raise_bits = raise_we ? wdata : '0;

    // One storage cell per source; set terms override the clear term
    for (genvar b = 0; b < NSRC; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                cause_q[b] <= 1'b0;
            end else if (evt[b] || raise_bits[b]) begin
                cause_q[b] <= 1'b1;
            end else if (w1c_hit[b] || cor_hit[b]) begin
                cause_q[b] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (mode_we) begin
            mode_q <= wdata;
        end
    end

endmodule

// File: rtl/irq_cm_mask.sv
module irq_cm_mask #(
    parameter int unsigned NSRC = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] wdata,
    input  logic            mval_we,
    input  logic            mset_we,
    input  logic            mclr_we,
    output logic [NSRC-1:0] mask_q
);
    logic [NSRC-1:0] mask_d;

    always_comb begin
        mask_d = mask_q;
        if (mval_we) mask_d = wdata;
        if (mset_we) mask_d = mask_d | wdata;
        if (mclr_we) mask_d = mask_d & ~wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
        end else begin
            mask_q <= mask_d;
        end
    end

endmodule

// File: rtl/irq_cause_mask_unit.sv
module irq_cause_mask_unit
    import irq_cm_pkg::*;
#(
    parameter int unsigned NSRC = 32,
    parameter int unsigned AW   = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   reg_addr,
    input  logic            reg_wr,
    input  logic [NSRC-1:0] reg_wdata,
    input  logic            reg_rd,
    output logic [NSRC-1:0] reg_rdata,
    input  logic [NSRC-1:0] evt_pulse,
    output logic            irq_out
);
    slot_e           slot;
    strobe_t         strb;
    logic [NSRC-1:0] mode_q;
    logic [NSRC-1:0] cause_q;
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] rd_mux;
    logic [NSRC-1:0] rdata_q;

    irq_cm_decode #(.AW(AW)) u_dec (
        .addr (reg_addr),
        .wr   (reg_wr),
        .rd   (reg_rd),
        .slot (slot),
        .strb (strb)
    );

    irq_cm_cause #(.NSRC(NSRC)) u_cause (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt_pulse),
        .wdata     (reg_wdata),
        .mask      (mask_q),
        .mode_we   (strb.mode_we),
        .cause_we  (strb.cause_we),
        .mcause_we (strb.mcause_we),
        .raise_we  (strb.raise_we),
        .cause_re  (strb.cause_re),
        .mcause_re (strb.mcause_re),
        .mode_q    (mode_q),
        .cause_q   (cause_q)
    );

    irq_cm_mask #(.NSRC(NSRC)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .wdata   (reg_wdata),
        .mval_we (strb.mval_we),
        .mset_we (strb.mset_we),
        .mclr_we (strb.mclr_we),
        .mask_q  (mask_q)
    );

    always_comb begin
        rd_mux = '0;
        if (!slot_reads_zero(slot)) begin
            unique case (slot)
                SLOT_MODE:   rd_mux = mode_q;
                SLOT_CAUSE:  rd_mux = cause_q;
                SLOT_MCAUSE: rd_mux = cause_q & ~mask_q;
                SLOT_MVAL:   rd_mux = mask_q;
                default:     rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (reg_rd) begin
            rdata_q <= rd_mux;
        end
    end

    assign reg_rdata = rdata_q;
    assign irq_out   = |(cause_q & ~mask_q);

endmodule

// File: rtl/irq_cm_checker.sv
module irq_cm_checker #(
    parameter int unsigned NSRC = 32,
    parameter int unsigned AW   = 3
) (
    input logic            clk,
    input logic            rst,
    input logic [AW-1:0]   reg_addr,
    input logic            reg_wr,
    input logic            reg_rd,
    input logic [NSRC-1:0] reg_wdata,
    input logic [NSRC-1:0] reg_rdata,
    input logic [NSRC-1:0] evt_pulse,
    input logic            irq_out,
    input logic [NSRC-1:0] cause_q,
    input logic [NSRC-1:0] mode_q,
    input logic [NSRC-1:0] mask_q,
    input logic            raise_we
);
    localparam logic [AW-1:0] W_CAUSE = AW'(1);
    localparam logic [AW-1:0] W_RAISE = AW'(3);
    localparam logic [AW-1:0] W_MSET  = AW'(5);
    localparam logic [AW-1:0] W_MCLR  = AW'(6);

    // R1: state straight after reset
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cause_q == '0 && mode_q == '0 && mask_q == '1 && !irq_out));

    // R2: every event bit is held at the next edge
    p_event_sticks_r2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((cause_q & $past(evt_pulse)) == $past(evt_pulse)));

    // R2: a cause bit rises only from an event or a cause-set write
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((cause_q & ~$past(cause_q) & ~$past(evt_pulse)
                   & ~($past(raise_we) ? $past(reg_wdata) : '0)) == '0));

    // R3: a plain cause read keeps every mode-0 bit
    p_read_keeps_w1c_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !reg_wr && reg_addr == W_CAUSE) |=>
            ((cause_q & $past(cause_q & ~mode_q)) == $past(cause_q & ~mode_q)));

    // R4: a cause read leaves no mode-1 bit set unless an event hit it
    p_cor_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !reg_wr && reg_addr == W_CAUSE) |=>
            ((cause_q & $past(mode_q) & ~$past(evt_pulse)) == '0));

    // R6 / R7: write-only ports return zero
    p_wo_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && (reg_addr == W_RAISE || reg_addr == W_MSET || reg_addr == W_MCLR))
            |=> (reg_rdata == '0));

    // R9: output agrees with the registered cause and mask
    p_irq_view_r9: assert property (@(posedge clk) disable iff (rst)
        irq_out == ((cause_q & ~mask_q) != '0));

endmodule

bind irq_cause_mask_unit irq_cm_checker #(.NSRC(NSRC), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .evt_pulse (evt_pulse),
    .irq_out   (irq_out),
    .cause_q   (cause_q),
    .mode_q    (mode_q),
    .mask_q    (mask_q),
    .raise_we  (strb.raise_we)
);

// File: tb/sim_irq_cause_mask_unit.sv
`timescale 1ns/1ps
module sim_irq_cause_mask_unit;
    localparam logic [2:0] A_MODE = 3'd0, A_CAUSE = 3'd1, A_MCAUSE = 3'd2,
                           A_RAISE = 3'd3, A_MVAL = 3'd4, A_MSET = 3'd5,
                           A_MCLR = 3'd6, A_UNUSED = 3'd7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] evt_pulse = '0;
    logic        irq_out;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    irq_cause_mask_unit u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .evt_pulse(evt_pulse), .irq_out(irq_out)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic r, input logic [2:0] a,
                       input logic [31:0] d, input logic [31:0] ev,
                       output logic [31:0] q);
        @(negedge clk);
        reg_addr = a; reg_wr = w; reg_rd = r; reg_wdata = d; evt_pulse = ev;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0; evt_pulse = '0;
        q = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        logic [31:0] q;
        acc(1'b1, 1'b0, a, d, '0, q);
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] q);
        acc(1'b0, 1'b1, a, '0, '0, q);
    endtask

    task automatic pulse(input logic [31:0] ev);
        logic [31:0] q;
        acc(1'b0, 1'b0, A_MODE, '0, ev, q);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] q;
        logic [31:0] expm;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk({31'b0, irq_out}, 32'h0, "R1 irq after reset");
        rd(A_MODE, q);  chk(q, 32'h0, "R1 mode reset");
        rd(A_CAUSE, q); chk(q, 32'h0, "R1 cause reset");
        rd(A_MVAL, q);  chk(q, 32'hFFFF_FFFF, "R1 mask reset");

        // R2 events latch; masked so R9 output stays low
        pulse(32'hA5A5_0003);
        chk({31'b0, irq_out}, 32'h0, "R9 all masked");
        rd(A_CAUSE, q); chk(q, 32'hA5A5_0003, "R2 event latch");
        rd(A_CAUSE, q); chk(q, 32'hA5A5_0003, "R2 sticky / R3 read keeps");

        // R3 write-one-to-clear
        wr(A_CAUSE, 32'h0000_0001);
        rd(A_CAUSE, q); chk(q, 32'hA5A5_0002, "R3 w1c clear");

        // R7 mask clear alias, R5 masked view, R9 output
        wr(A_MCLR, 32'hFFFF_0000);
        rd(A_MVAL, q);   chk(q, 32'h0000_FFFF, "R7 mask clear alias");
        rd(A_MCLR, q);   chk(q, 32'h0, "R7 mclr reads zero");
        rd(A_MSET, q);   chk(q, 32'h0, "R7 mset reads zero");
        rd(A_MCAUSE, q); chk(q, 32'hA5A5_0000, "R5 masked view");
        chk({31'b0, irq_out}, 32'h1, "R9 irq high");

        // R11 mode register, R4 clear-on-read
        wr(A_MODE, 32'hFF00_0000);
        rd(A_MODE, q);  chk(q, 32'hFF00_0000, "R11 mode readback");
        rd(A_CAUSE, q); chk(q, 32'hA5A5_0002, "R4 read returns");
        rd(A_CAUSE, q); chk(q, 32'h00A5_0002, "R4 cor cleared top byte");
        wr(A_CAUSE, 32'h00FF_0000);
        rd(A_CAUSE, q); chk(q, 32'h0000_0002, "R3 w1c mid byte");

        // R6 cause-set, R4 write ignored for cor bit
        wr(A_RAISE, 32'h8000_0000);
        rd(A_RAISE, q); chk(q, 32'h0, "R6 raise reads zero");
        wr(A_CAUSE, 32'h8000_0000);
        // R5 masked cor read returns bit31 only and clears it
        rd(A_MCAUSE, q); chk(q, 32'h8000_0000, "R4 write ignored / R6 set");
        rd(A_CAUSE, q);  chk(q, 32'h0000_0002, "R5 masked cor clear");
        wr(A_MCAUSE, 32'h0000_0002);
        rd(A_CAUSE, q);  chk(q, 32'h0000_0002, "R5 masked w1c skips hidden bit");
        wr(A_MVAL, 32'h0);
        rd(A_MVAL, q);   chk(q, 32'h0, "R7 mask direct write");
        wr(A_MCAUSE, 32'h0000_0002);
        rd(A_CAUSE, q);  chk(q, 32'h0, "R5 masked w1c clear");
        chk({31'b0, irq_out}, 32'h0, "R9 irq low");

        // R8 event beats a same-cycle clear
        pulse(32'h0000_0001);
        acc(1'b1, 1'b0, A_CAUSE, 32'h0000_0001, 32'h0000_0001, q);
        rd(A_CAUSE, q); chk(q, 32'h0000_0001, "R8 event over w1c");
        wr(A_CAUSE, 32'h0000_0001);
        wr(A_RAISE, 32'h0100_0000);
        acc(1'b0, 1'b1, A_CAUSE, '0, 32'h0100_0000, q);
        chk(q, 32'h0100_0000, "R8 cor read value");
        rd(A_CAUSE, q); chk(q, 32'h0100_0000, "R8 event over cor");
        rd(A_CAUSE, q); chk(q, 32'h0, "R4 cor final clear");

        // R10 unused word
        wr(A_UNUSED, 32'hFFFF_FFFF);
        rd(A_UNUSED, q); chk(q, 32'h0, "R10 unused reads zero");
        rd(A_CAUSE, q);  chk(q, 32'h0, "R10 unused write no cause");
        rd(A_MVAL, q);   chk(q, 32'h0, "R10 unused write no mask");
        rd(A_MODE, q);   chk(q, 32'hFF00_0000, "R10 unused write no mode");

        // Sweep every source with alternating clear modes (odd bits cor)
        wr(A_MODE, 32'hAAAA_AAAA);
        for (int i = 0; i < 32; i++) begin
            pulse(32'h1 << i);
            chk({31'b0, irq_out}, 32'h1, $sformatf("R9 sweep irq bit %0d", i));
            rd(A_CAUSE, q); chk(q, 32'h1 << i, $sformatf("R2 sweep bit %0d", i));
            if (i % 2 == 1) begin
                rd(A_CAUSE, q); chk(q, 32'h0, $sformatf("R4 sweep bit %0d", i));
            end else begin
                rd(A_CAUSE, q); chk(q, 32'h1 << i, $sformatf("R3 sweep keep bit %0d", i));
                wr(A_CAUSE, 32'h1 << i);
                rd(A_CAUSE, q); chk(q, 32'h0, $sformatf("R3 sweep clear bit %0d", i));
            end
            chk({31'b0, irq_out}, 32'h0, $sformatf("R9 sweep low bit %0d", i));
        end

        // R7 mask-set accumulation then mask-clear removal
        for (int i = 0; i < 32; i++) begin
            wr(A_MSET, 32'h1 << i);
            expm = 32'((64'h2 << i) - 64'h1);
            rd(A_MVAL, q); chk(q, expm, $sformatf("R7 mset bit %0d", i));
        end
        for (int i = 0; i < 32; i += 3) begin
            wr(A_MCLR, 32'h1 << i);
            rd(A_MVAL, q);
            chk(q & (32'h1 << i), 32'h0, $sformatf("R7 mclr bit %0d", i));
        end

        done = 1'b1;
        finish_run();
    end
endmodule